// File: doc/BRIEF.md
# Network Interface Flit Packetizer

This block is the initiator side of a network interface for a wormhole-switched on-chip network. A core issues a read or write request with a transaction address and a burst length. The block latches the address into a header register. It looks up a source route in a small table indexed by the upper address bits. It then emits one header flit followed by payload flits, and marks the final flit as the tail so that switches can release the path.

Write data beats are loaded one at a time into per-beat payload storage. Flits may leave as soon as their beat has arrived. Every flit stays held until the link acknowledges it. The link returns one ACK or NACK per flit, in order. A NACK makes the block wait for the remaining responses of that attempt and then resend the whole packet from the header flit. The core is held off until the packet is fully acknowledged.

A receive stage accepts flits from the network into a two-entry buffer. It answers each flit with ACK or NACK one cycle later, using the same go-back-N rule as the switches.

Top module: `ni_pktz`

## Requirements
- R1: After reset, tx_valid, wr_ready, rsp_valid, rx_ack and rx_nack are 0 and req_ready is 1.
- R2: The first flit of every packet has type code 2'b01 (head) in flit bits [33:32]. Its payload holds the address in [15:0], the write flag in [16], the beat count minus one in [19:17], zeros in [23:20], and in [31:24] the route entry chosen by address bits [15:14] (entries 0..3: 8'h05, 8'h12, 8'h21, 8'h3C).
- R3: A write of req_len+1 beats produces the head flit followed by the beats in order. Each beat is typed 2'b10 (body), except the last, which is 2'b11 (tail). A single-beat write gives head then tail.
- R4: A read produces a head flit followed by one tail flit with an all-zero payload.
- R5: req_ready is 0 from request acceptance until every flit of the packet has been acknowledged in one attempt. wr_ready is 1 only while the accepted write still has beats to load. No flit is sent after the packet completes.
- R6: After a NACK, once all outstanding responses have returned, the block resends the whole packet starting with a head flit. Flits sent before the NACK are never counted as part of the final attempt.
- R7: At most WIN (4) flits are unacknowledged at any time, and the limit is reached when responses are slow.
- R8: A received flit is stored when the two-entry buffer has room. It is answered with rx_ack in the next cycle, and stored flits are delivered on rsp_flit in arrival order.
- R9: A received flit that finds the buffer full is answered with rx_nack. Every following non-head flit is then also refused, even if there is room, until a head flit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Transaction address |
| req_len | input | 3 | Burst beats minus one |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat accepted |
| wr_data | input | 32 | Write beat data |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_flit | output | 34 | Outgoing flit: type [33:32], payload [31:0] |
| tx_ack | input | 1 | Link acknowledges the oldest outstanding flit |
| tx_nack | input | 1 | Link rejects the oldest outstanding flit |
| rx_valid | input | 1 | Incoming flit valid |
| rx_flit | input | 34 | Incoming flit |
| rx_ack | output | 1 | Incoming flit of previous cycle accepted |
| rx_nack | output | 1 | Incoming flit of previous cycle refused |
| rsp_valid | output | 1 | Buffered flit available |
| rsp_flit | output | 34 | Oldest buffered flit |
| rsp_ready | input | 1 | Core takes the buffered flit |

## Verification
The bench rejects the header flit itself, rejects a body flit in the middle of a long burst, and rejects the tail. A design that resumed from the rejected flit instead of the header would show one head flit in the log rather than two. A design that counted late acknowledgements from the dropped attempt would finish early with a truncated final packet. Slow acknowledgements push the outstanding count to the window limit, and a design with a broken limit would overrun it. Gapped write beats expose a design that sends a payload flit before its beat has arrived. On the receive side, the bench sends a flit into a full buffer and then a body flit after the buffer drains. A design without the drop state would wrongly accept that body flit and splice a broken packet.

// File: rtl/ni_pktz.sv
module ni_pktz #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int LW   = 3,
  parameter int RW   = 8,
  parameter int IDXW = 2,
  parameter int WIN  = 4,
  parameter logic [(1<<IDXW)*RW-1:0] ROUTE_TABLE = {8'h3C, 8'h21, 8'h12, 8'h05}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          tx_valid,
  output logic [DW+1:0] tx_flit,
  input  logic          tx_ack,
  input  logic          tx_nack,
  input  logic          rx_valid,
  input  logic [DW+1:0] rx_flit,
  output logic          rx_ack,
  output logic          rx_nack,
  output logic          rsp_valid,
  output logic [DW+1:0] rsp_flit,
  input  logic          rsp_ready
);
  localparam int FW   = DW + 2;
  localparam int MAXB = 1 << LW;
  localparam int CW   = $clog2(MAXB + 2);
  localparam int OW   = $clog2(WIN + 1);
  localparam logic [1:0] FT_HEAD = 2'b01, FT_BODY = 2'b10, FT_TAIL = 2'b11;

  logic          busy, is_wr, rewind;
  logic [DW-1:0] hdr_q, hdr_word;
  logic [CW-1:0] nflits, loaded, snd, acked;
  logic [OW-1:0] outst, outst_n;
  logic [DW-1:0] beat_mem [MAXB];
  logic [RW-1:0] route;
  logic [LW-1:0] rd_idx, wr_idx;
  logic [1:0]    cur_type;
  logic [DW-1:0] cur_pay;
  logic          accept, wr_fire, send, resp;

  assign req_ready = !busy;
  assign wr_ready  = busy && is_wr && (loaded < nflits);
  assign accept    = req_valid && req_ready;
  assign wr_fire   = wr_valid && wr_ready;
  assign resp      = tx_ack || tx_nack;
  assign send      = busy && !rewind && (snd < loaded) && (outst < OW'(WIN));
  assign outst_n   = outst + OW'(send) - OW'(resp);
  assign route     = ROUTE_TABLE[req_addr[AW-1 -: IDXW]*RW +: RW];
  assign rd_idx    = LW'(snd - CW'(1));
  assign wr_idx    = LW'(loaded - CW'(1));

  always_comb begin
    hdr_word             = '0;
    hdr_word[AW-1:0]     = req_addr;
    hdr_word[AW]         = req_write;
    hdr_word[AW+LW:AW+1] = req_len;
    hdr_word[DW-1 -: RW] = route;
  end

  always_comb begin
    if (snd == '0) begin
      cur_type = FT_HEAD;
      cur_pay  = hdr_q;
    end else begin
      cur_type = (snd == nflits - CW'(1)) ? FT_TAIL : FT_BODY;
      cur_pay  = is_wr ? beat_mem[rd_idx] : '0;
    end
  end

  always_ff @(posedge clk)
    if (busy && wr_fire) beat_mem[wr_idx] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_wr    <= 1'b0;
      rewind   <= 1'b0;
      hdr_q    <= '0;
      nflits   <= '0;
      loaded   <= '0;
      snd      <= '0;
      acked    <= '0;
      outst    <= '0;
      tx_valid <= 1'b0;
      tx_flit  <= '0;
    end else begin
      tx_valid <= send;
      if (send) tx_flit <= {cur_type, cur_pay};
      outst <= outst_n;
      if (accept) begin
        busy   <= 1'b1;
        hdr_q  <= hdr_word;
        is_wr  <= req_write;
        nflits <= req_write ? CW'(req_len) + CW'(2) : CW'(2);
        loaded <= req_write ? CW'(1) : CW'(2);
        snd    <= '0;
        acked  <= '0;
        rewind <= 1'b0;
      end else if (busy) begin
        if (wr_fire) loaded <= loaded + CW'(1);
        if (rewind && outst_n == '0) begin
          snd    <= '0;
          acked  <= '0;
          rewind <= 1'b0;
        end else begin
          if (send) snd <= snd + CW'(1);
          if (tx_nack) rewind <= 1'b1;
          else if (tx_ack && !rewind) begin
            if (acked + CW'(1) == nflits) busy <= 1'b0;
            else acked <= acked + CW'(1);
          end
        end
      end
    end
  end

  logic [FW-1:0] rxm [2];
  logic          wp, rp, drop_q;
  logic [1:0]    cnt;
  logic          rx_head, room, take, refuse, pop;

  assign rx_head   = rx_flit[FW-1 -: 2] == FT_HEAD;
  assign room      = cnt != 2'd2;
  assign take      = rx_valid && room && (rx_head || !drop_q);
  assign refuse    = rx_valid && !take;
  assign rsp_valid = cnt != 2'd0;
  assign rsp_flit  = rxm[rp];
  assign pop       = rsp_valid && rsp_ready;

  always_ff @(posedge clk)
    if (take) rxm[wp] <= rx_flit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= 1'b0;
      rp      <= 1'b0;
      cnt     <= '0;
      drop_q  <= 1'b0;
      rx_ack  <= 1'b0;
      rx_nack <= 1'b0;
    end else begin
      rx_ack  <= take;
      rx_nack <= refuse;
      if (take) wp <= ~wp;
      if (pop) rp <= ~rp;
      cnt <= cnt + 2'(take) - 2'(pop);
      if (refuse) drop_q <= 1'b1;
      else if (take && rx_head) drop_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ni_pktz_chk.sv
module ni_pktz_chk #(
  parameter int DW  = 32,
  parameter int WIN = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          wr_ready,
  input logic          tx_valid,
  input logic [DW+1:0] tx_flit,
  input logic          tx_ack,
  input logic          tx_nack,
  input logic          rx_valid,
  input logic          rx_ack,
  input logic          rx_nack
);
  logic [7:0] inflight;
  logic       head_due;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight <= '0;
      head_due <= 1'b0;
    end else begin
      inflight <= inflight + 8'(tx_valid) - 8'(tx_ack || tx_nack);
      if (req_valid && req_ready) head_due <= 1'b1;
      else if (tx_valid) head_due <= 1'b0;
    end
  end

  p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 8'(WIN));

  p_head_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (head_due && tx_valid) |-> tx_flit[DW+1:DW] == 2'b01);

  p_busy_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !req_ready);

  p_busy_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !req_ready);

  p_rx_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (rx_ack != rx_nack));

  p_rx_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !(rx_ack || rx_nack));
endmodule

bind ni_pktz ni_pktz_chk #(.DW(DW), .WIN(WIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .wr_ready(wr_ready), .tx_valid(tx_valid), .tx_flit(tx_flit),
  .tx_ack(tx_ack), .tx_nack(tx_nack), .rx_valid(rx_valid),
  .rx_ack(rx_ack), .rx_nack(rx_nack)
);

// File: tb/ni_pktz_tb_top.sv
`timescale 1ns/1ps
module ni_pktz_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, wr_valid = 0, rx_valid = 0, rsp_ready = 0;
  logic [15:0] req_addr = '0;
  logic [2:0]  req_len = '0;
  logic [31:0] wr_data = '0;
  logic [33:0] rx_flit = '0;
  logic tx_ack = 0, tx_nack = 0;
  logic req_ready, wr_ready, tx_valid, rx_ack, rx_nack, rsp_valid;
  logic [33:0] tx_flit, rsp_flit;

  always #2.5 clk = ~clk;

  ni_pktz dut_i (.*);

  int checks = 0, errors = 0;
  logic [33:0] log_q [64];
  int n_log = 0, nack_at = -1, delay = 0, cyc = 0;
  int pend_t [64];
  bit pend_n [64];
  int ph = 0, pt = 0, max_out = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tx_ack = 0; tx_nack = 0;
    if (tx_valid) begin
      log_q[n_log % 64] = tx_flit;
      pend_n[pt % 64] = (n_log == nack_at);
      pend_t[pt % 64] = cyc + delay;
      pt++; n_log++;
    end
    if (pt - ph > max_out) max_out = pt - ph;
    if (ph < pt && pend_t[ph % 64] <= cyc) begin
      if (pend_n[ph % 64]) tx_nack = 1; else tx_ack = 1;
      ph++;
    end
  end

  function automatic logic [7:0] route_of(input logic [1:0] i);
    case (i)
      2'd0: return 8'h05;
      2'd1: return 8'h12;
      2'd2: return 8'h21;
      default: return 8'h3C;
    endcase
  endfunction

  function automatic logic [31:0] beat_of(input logic [15:0] a, input int i);
    return {8'hA5, a, 8'(i * 17 + 3)};
  endfunction

  task automatic run_pkt(input string tag, input bit wr, input logic [15:0] addr,
                         input logic [2:0] len, input int nk, input int dly, input int gap);
    logic [33:0] exp [10];
    int nf, heads, base;
    bit ok;
    nf = wr ? int'(len) + 2 : 2;
    exp[0] = {2'b01, route_of(addr[15:14]), 4'h0, len, wr, addr};
    if (wr) for (int i = 1; i < nf; i++) exp[i] = {(i == nf - 1) ? 2'b11 : 2'b10, beat_of(addr, i - 1)};
    else exp[1] = {2'b11, 32'h0};
    n_log = 0; ph = 0; pt = 0; max_out = 0; nack_at = nk; delay = dly;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_len = len;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, {tag, " R5 req_ready low after accept"}, 64'(req_ready), 0);
    if (wr) for (int i = 0; i <= int'(len); i++) begin
      for (int g = 0; g < gap; g++) @(negedge clk);
      wr_valid = 1; wr_data = beat_of(addr, i);
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      wr_valid = 0;
    end
    check(!wr_ready, {tag, " R5 wr_ready low when no beats owed"}, 64'(wr_ready), 0);
    while (!req_ready) @(negedge clk);
    base = n_log;
    repeat (6) @(negedge clk);
    check(n_log == base, {tag, " R5 no flit after completion"}, 64'(n_log), 64'(base));
    heads = 0;
    for (int i = 0; i < n_log; i++) if (log_q[i][33:32] == 2'b01) heads++;
    check(heads == ((nk >= 0) ? 2 : 1), {tag, " R6 head flit count"}, 64'(heads), 64'((nk >= 0) ? 2 : 1));
    check(log_q[0] == exp[0], {tag, " R2 first flit is header"}, 64'(log_q[0]), 64'(exp[0]));
    ok = n_log >= nf;
    for (int i = 0; i < nf && ok; i++)
      if (log_q[n_log - nf + i] !== exp[i]) begin
        ok = 0;
        check(0, {tag, " R3 R4 final attempt flit"}, 64'(log_q[n_log - nf + i]), 64'(exp[i]));
      end
    if (ok) check(1, {tag, " R3 R4 final attempt"}, 0, 0);
    if (nk >= 0) begin
      ok = 1;
      for (int i = 0; i <= nk && i < nf; i++) if (log_q[i] !== exp[i]) ok = 0;
      check(ok && n_log >= nf + nk + 1, {tag, " R6 prefix and resend length"}, 64'(n_log), 64'(nf + nk + 1));
    end
    if (dly > 4) check(max_out == 4, {tag, " R7 window reached"}, 64'(max_out), 4);
    else check(max_out <= 4, {tag, " R7 window bound"}, 64'(max_out), 4);
    nack_at = -1; delay = 0;
  endtask

  task automatic rx_send(input logic [33:0] f, input bit exp_ack, input string tag);
    rx_valid = 1; rx_flit = f;
    @(negedge clk);
    rx_valid = 0;
    check(rx_ack == exp_ack && rx_nack == !exp_ack, tag, 64'({rx_ack, rx_nack}), 64'({exp_ack, !exp_ack}));
  endtask

  task automatic rx_pop(input logic [33:0] f, input string tag);
    check(rsp_valid && rsp_flit == f, tag, 64'(rsp_flit), 64'(f));
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic run_rx;
    @(negedge clk);
    rx_send({2'b01, 32'h1111_0001}, 1, "R8 head accepted");
    check(rsp_valid, "R8 rsp_valid after accept", 64'(rsp_valid), 1);
    rx_send({2'b10, 32'h2222_0002}, 1, "R8 body accepted");
    rx_send({2'b10, 32'h3333_0003}, 0, "R9 full buffer refuses");
    rx_send({2'b11, 32'h4444_0004}, 0, "R9 tail refused while full");
    rx_pop({2'b01, 32'h1111_0001}, "R8 first delivered");
    rx_pop({2'b10, 32'h2222_0002}, "R8 second delivered");
    check(!rsp_valid, "R8 buffer empty", 64'(rsp_valid), 0);
    rx_send({2'b10, 32'h5555_0005}, 0, "R9 body dropped with room");
    check(!rsp_valid, "R9 dropped body not stored", 64'(rsp_valid), 0);
    rx_send({2'b01, 32'h6666_0006}, 1, "R9 head ends drop");
    rx_send({2'b11, 32'h7777_0007}, 1, "R8 tail after head");
    rx_pop({2'b01, 32'h6666_0006}, "R8 order head");
    rx_pop({2'b11, 32'h7777_0007}, "R8 order tail");
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!tx_valid && req_ready && !wr_ready && !rsp_valid && !rx_ack && !rx_nack,
          "R1 reset state", 64'({tx_valid, req_ready, wr_ready, rsp_valid, rx_ack, rx_nack}), 64'(6'b010000));
    rst_n = 1;
    run_pkt("burst4", 1, 16'h4123, 3'd3, -1, 0, 0);
    run_pkt("single", 1, 16'hC00F, 3'd0, -1, 0, 0);
    run_pkt("read", 0, 16'h8ABC, 3'd5, -1, 0, 0);
    run_pkt("gapped", 1, 16'h0042, 3'd4, -1, 0, 3);
    run_pkt("nack_mid", 1, 16'h0042, 3'd7, 4, 0, 0);
    run_pkt("nack_head", 1, 16'h9001, 3'd2, 0, 0, 0);
    run_pkt("nack_tail", 0, 16'h7F00, 3'd0, 1, 0, 0);
    run_pkt("slow_ack", 1, 16'hE0E0, 3'd7, -1, 8, 0);
    run_pkt("slow_nack", 1, 16'h2345, 3'd6, 2, 6, 0);
    run_rx();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule